// File: doc/BRIEF.md
# Integer and Single-Precision Float Converter

This block turns a 32-bit two's-complement integer into an IEEE-754 single-precision value, or turns such a value back into a signed 32-bit integer. The caller chooses the direction with a function code. The rounding direction comes from a 2-bit mode field that is sampled with each request, so the value in the status register at issue time takes effect without a pipeline flush.

A request is a one-cycle `in_valid` strobe carrying the function code, the operand and the mode. The block runs a short three-state sequence. In the first state the operand is shaped: for int-to-float a leading-zero count normalizes it, and for float-to-int the significand is aligned by its exponent. Both directions then go through one shared rounding incrementer, and the packed result appears together with a single-cycle `out_done`. A float-to-int conversion that has no representable answer saturates and raises `out_invalid` in the same cycle as `out_done`.

Top module: `fcvt_unit`

## Requirements
- R1: Int-to-float rounds a magnitude that needs more than 24 significant bits according to `in_rmode`: 0 is round to nearest with ties to even, 1 is toward zero, 2 is toward +infinity and 3 is toward -infinity. A carry out of the significand increments the exponent.
- R2: Int-to-float is exact for magnitudes with at most 24 significant bits. Zero gives 0x00000000, 0x80000000 gives 0xCF000000, and the result is never 0x80000000 (negative zero).
- R3: Float-to-int rounds away the fractional part according to the same mode encoding and returns a two's-complement word.
- R4: Float-to-int returns 0x7FFFFFFF for NaN, for +infinity and for values at or above 2^31. It returns 0x80000000 for -infinity and for values below -2^31. Each of these cases sets `out_invalid`. An input of exactly -2^31 (0xCF000000) gives 0x80000000 with `out_invalid` low.
- R5: Float-to-int of a denormal, or of any value with magnitude below 1, gives 0. It gives +1 when the value is positive and nonzero and the mode is 2, and -1 (0xFFFFFFFF) when the value is negative and nonzero and the mode is 3. Negative zero gives 0.
- R6: `in_func` 0x04 selects int-to-float and 0x05 selects float-to-int. A strobe with any other code is ignored: no `out_done` follows and `out_result` is unchanged.
- R7: `out_done` is high for exactly one cycle per accepted request, in the cycle after the second rising edge that follows the accepting edge. `out_invalid` is high only while `out_done` is high.
- R8: A strobe that arrives while a conversion is in progress is ignored and does not alter the result of that conversion.
- R9: `out_result` changes only in a cycle where `out_done` is high and holds its value between completions.
- R10: After reset, `out_done` and `out_invalid` are low and `out_result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | One-cycle request strobe |
| in_func | input | 8 | Function code: 0x04 int-to-float, 0x05 float-to-int |
| in_opnd | input | 32 | Source operand |
| in_rmode | input | 2 | Rounding direction sampled with the request |
| out_result | output | 32 | Converted value, held until the next completion |
| out_done | output | 1 | One-cycle completion pulse |
| out_invalid | output | 1 | Float-to-int saturation or NaN, valid with `out_done` |

## Verification
The embedded properties assume that `in_valid` is only raised while `rst_n` is high, and that the operand and mode are meaningful only in the cycle the strobe is sampled. The stimulus changes its inputs only on falling edges and drops the strobe after one cycle, except in the deliberate busy-overlap case. Random float-to-int operands are drawn mostly from exponents near the integer range, so that rounding, saturation and sub-unity values are all exercised. Fully random bit patterns are mixed in to reach NaN, infinities and denormals.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

   typedef enum logic [1:0] {
      RM_NEAREST_EVEN = 2'd0,
      RM_TO_ZERO      = 2'd1,
      RM_TO_POS       = 2'd2,
      RM_TO_NEG       = 2'd3
   } fcvt_rmode_e;

   typedef enum logic [1:0] {
      CV_IDLE  = 2'd0,
      CV_SHAPE = 2'd1,
      CV_ROUND = 2'd2
   } fcvt_state_e;

endpackage

// File: rtl/fcvt_lzc.sv
module fcvt_lzc #(
   parameter int W  = 32,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] zeros
);

   // the highest set bit wins because it is visited last
   always_comb begin
      zeros = CW'(W);
      for (int i = 0; i < W; i++) begin
         if (vec[i]) zeros = CW'(W - 1 - i);
      end
   end

endmodule

// File: rtl/fcvt_round.sv
module fcvt_round
   import fcvt_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] mag,
   input  logic         guard,
   input  logic         sticky,
   input  logic         neg,
   input  fcvt_rmode_e  mode,
   output logic [W-1:0] sum
);

   logic bump;

   always_comb begin
      unique case (mode)
         RM_NEAREST_EVEN: bump = guard & (sticky | mag[0]);
         RM_TO_ZERO:      bump = 1'b0;
         RM_TO_POS:       bump = ~neg & (guard | sticky);
         RM_TO_NEG:       bump = neg & (guard | sticky);
         default:         bump = 1'b0;
      endcase
      sum = mag + W'(bump);
   end

endmodule

// File: rtl/fcvt_i2f_shape.sv
module fcvt_i2f_shape #(
   parameter int INT_W = 32,
   parameter int SIG_W = 24,
   parameter int CW    = $clog2(INT_W + 1)
) (
   input  logic [INT_W-1:0] opnd,
   output logic             neg,
   output logic             zero,
   output logic [SIG_W-1:0] keep,
   output logic             guard,
   output logic             sticky,
   output logic [CW-1:0]    msb
);

   localparam int DROP_W = INT_W - SIG_W;

   logic [INT_W-1:0] absv;
   logic [INT_W-1:0] norm;
   logic [CW-1:0]    lz;

   assign neg  = opnd[INT_W-1];
   assign absv = neg ? (INT_W'(0) - opnd) : opnd;
   assign zero = (absv == '0);

   fcvt_lzc #(.W(INT_W), .CW(CW)) u_lzc (
      .vec   (absv),
      .zeros (lz)
   );

   assign norm   = absv << lz;
   assign keep   = norm[INT_W-1 -: SIG_W];
   assign guard  = norm[DROP_W-1];
   assign sticky = |norm[DROP_W-2:0];
   assign msb    = CW'(INT_W - 1) - lz;

endmodule

// File: rtl/fcvt_f2i_align.sv
module fcvt_f2i_align #(
   parameter int INT_W = 32,
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [INT_W-1:0] opnd,
   output logic             neg,
   output logic [INT_W-1:0] mag,
   output logic             guard,
   output logic             sticky,
   output logic             bad,
   output logic [INT_W-1:0] bad_val
);

   localparam int SIG_W = MAN_W + 1;
   localparam int FR_W  = SIG_W + INT_W;
   localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
   localparam int EMAX  = (1 << EXP_W) - 1;
   localparam int E_LSH = BIAS + MAN_W;       // first exponent with no fraction
   localparam int E_TOP = BIAS + INT_W - 1;   // exponent of 2^(INT_W-1)

   logic [EXP_W-1:0] ex;
   logic [MAN_W-1:0] fr;
   logic [SIG_W-1:0] sig;
   logic [FR_W-1:0]  frame;
   logic             is_nan;
   int               ev;

   assign neg    = opnd[INT_W-1];
   assign ex     = opnd[INT_W-2 -: EXP_W];
   assign fr     = opnd[MAN_W-1:0];
   assign sig    = {1'b1, fr};
   assign ev     = int'(ex);
   assign is_nan = (ev == EMAX) && (fr != '0);
   assign frame  = {sig, {INT_W{1'b0}}} >> (E_LSH - ev);

   assign bad_val = (is_nan || !neg) ? {1'b0, {(INT_W-1){1'b1}}}
                                     : {1'b1, {(INT_W-1){1'b0}}};

   always_comb begin
      mag    = '0;
      guard  = 1'b0;
      sticky = 1'b0;
      bad    = 1'b0;
      if (ev == EMAX || ev > E_TOP || (ev == E_TOP && !(neg && fr == '0))) begin
         bad = 1'b1;
      end else if (ev == 0) begin
         sticky = (fr != '0);
      end else if (ev >= E_LSH) begin
         mag = INT_W'(sig) << (ev - E_LSH);
      end else if (ev >= E_LSH - INT_W) begin
         mag    = {{(INT_W-SIG_W){1'b0}}, frame[FR_W-1:INT_W]};
         guard  = frame[INT_W-1];
         sticky = |frame[INT_W-2:0];
      end else begin
         sticky = 1'b1;
      end
   end

endmodule

// File: rtl/fcvt_unit.sv
module fcvt_unit
   import fcvt_pkg::*;
#(
   parameter int                INT_W    = 32,
   parameter int                EXP_W    = 8,
   parameter int                MAN_W    = 23,
   parameter int                FUNC_W   = 8,
   parameter logic [FUNC_W-1:0] CODE_I2F = FUNC_W'(4),
   parameter logic [FUNC_W-1:0] CODE_F2I = FUNC_W'(5)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [FUNC_W-1:0] in_func,
   input  logic [INT_W-1:0]  in_opnd,
   input  logic [1:0]        in_rmode,
   output logic [INT_W-1:0]  out_result,
   output logic              out_done,
   output logic              out_invalid
);

   localparam int SIG_W = MAN_W + 1;
   localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
   localparam int CW    = $clog2(INT_W + 1);

   if (INT_W != 1 + EXP_W + MAN_W) begin : g_bad_pack
      $error("fcvt_unit: INT_W must equal 1 + EXP_W + MAN_W");
   end
   if (INT_W - SIG_W < 2) begin : g_bad_drop
      $error("fcvt_unit: need at least two dropped bits for guard and sticky");
   end
   if (BIAS + MAN_W <= INT_W) begin : g_bad_bias
      $error("fcvt_unit: exponent range too narrow for the integer width");
   end
   if (CODE_I2F == CODE_F2I) begin : g_bad_code
      $error("fcvt_unit: function codes must differ");
   end

   fcvt_state_e      state;
   logic [INT_W-1:0] op_q;
   fcvt_rmode_e      mode_q;
   logic             i2f_q;
   logic             accept;

   logic             i_neg, i_zero, i_g, i_s;
   logic [SIG_W-1:0] i_keep;
   logic [CW-1:0]    i_msb;
   logic             f_neg, f_g, f_s, f_bad;
   logic [INT_W-1:0] f_mag, f_badval;

   logic             st_neg, st_g, st_s, st_zero, st_bad;
   logic [INT_W-1:0] st_mag, st_badval;
   logic [EXP_W-1:0] st_exp;
   logic [INT_W-1:0] r_sum;
   logic [INT_W-1:0] i2f_word, f2i_word;

   assign accept = in_valid && (state == CV_IDLE) &&
                   ((in_func == CODE_I2F) || (in_func == CODE_F2I));

   fcvt_i2f_shape #(.INT_W(INT_W), .SIG_W(SIG_W), .CW(CW)) u_i2f (
      .opnd   (op_q),
      .neg    (i_neg),
      .zero   (i_zero),
      .keep   (i_keep),
      .guard  (i_g),
      .sticky (i_s),
      .msb    (i_msb)
   );

   fcvt_f2i_align #(.INT_W(INT_W), .EXP_W(EXP_W), .MAN_W(MAN_W)) u_f2i (
      .opnd    (op_q),
      .neg     (f_neg),
      .mag     (f_mag),
      .guard   (f_g),
      .sticky  (f_s),
      .bad     (f_bad),
      .bad_val (f_badval)
   );

   fcvt_round #(.W(INT_W)) u_round (
      .mag    (st_mag),
      .guard  (st_g),
      .sticky (st_s),
      .neg    (st_neg),
      .mode   (mode_q),
      .sum    (r_sum)
   );

   // carry out of the significand moves the exponent up by one
   assign i2f_word = st_zero ? '0
                   : {st_neg, st_exp + EXP_W'(r_sum[SIG_W]), r_sum[MAN_W-1:0]};
   assign f2i_word = st_neg ? (INT_W'(0) - r_sum) : r_sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= CV_IDLE;
         op_q        <= '0;
         mode_q      <= RM_NEAREST_EVEN;
         i2f_q       <= 1'b0;
         st_neg      <= 1'b0;
         st_g        <= 1'b0;
         st_s        <= 1'b0;
         st_zero     <= 1'b0;
         st_bad      <= 1'b0;
         st_mag      <= '0;
         st_badval   <= '0;
         st_exp      <= '0;
         out_result  <= '0;
         out_done    <= 1'b0;
         out_invalid <= 1'b0;
      end else begin
         out_done    <= 1'b0;
         out_invalid <= 1'b0;
         unique case (state)
            CV_IDLE: begin
               if (accept) begin
                  op_q   <= in_opnd;
                  mode_q <= fcvt_rmode_e'(in_rmode);
                  i2f_q  <= (in_func == CODE_I2F);
                  state  <= CV_SHAPE;
               end
            end
            CV_SHAPE: begin
               st_neg    <= i2f_q ? i_neg : f_neg;
               st_mag    <= i2f_q ? {{(INT_W-SIG_W){1'b0}}, i_keep} : f_mag;
               st_g      <= i2f_q ? i_g : f_g;
               st_s      <= i2f_q ? i_s : f_s;
               st_exp    <= EXP_W'(BIAS) + EXP_W'(i_msb);
               st_zero   <= i2f_q & i_zero;
               st_bad    <= ~i2f_q & f_bad;
               st_badval <= f_badval;
               state     <= CV_ROUND;
            end
            CV_ROUND: begin
               out_result  <= st_bad ? st_badval : (i2f_q ? i2f_word : f2i_word);
               out_invalid <= st_bad;
               out_done    <= 1'b1;
               state       <= CV_IDLE;
            end
            default: state <= CV_IDLE;
         endcase
      end
   end

   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |=> !out_done);

   a_r7_invalid_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      out_invalid |-> out_done);

   a_r4_invalid_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      out_invalid |-> (out_result == {1'b0, {(INT_W-1){1'b1}}} ||
                       out_result == {1'b1, {(INT_W-1){1'b0}}}));

   a_r2_no_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_done && i2f_q) |-> (out_result != {1'b1, {(INT_W-1){1'b0}}}));

   a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
      !out_done |-> $stable(out_result));

   a_r8_operand_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (state != CV_IDLE) |=> $stable(op_q));

endmodule

// File: tb/tb_fcvt_unit.sv
`timescale 1ns/1ps
module tb_fcvt_unit;

   localparam logic [7:0] FN_I2F = 8'h04;
   localparam logic [7:0] FN_F2I = 8'h05;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_func = 8'h00;
   logic [31:0] in_opnd = 32'h0;
   logic [1:0]  in_rmode = 2'd0;
   logic [31:0] out_result;
   logic        out_done;
   logic        out_invalid;

   int n_vec = 0;
   int n_bad = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   fcvt_unit dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_func     (in_func),
      .in_opnd     (in_opnd),
      .in_rmode    (in_rmode),
      .out_result  (out_result),
      .out_done    (out_done),
      .out_invalid (out_invalid)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL R7 watchdog: actual=no completion expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   task automatic note(input bit ok, input string req, input logic [32:0] act,
                       input logic [32:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%09h expected=%09h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_itof(input logic [31:0] x, input logic [1:0] rm);
      longint mag, keep, rem, half;
      int     p;
      bit     neg, up;
      neg = x[31];
      mag = longint'({32'd0, x});
      if (neg) mag = 64'sh1_0000_0000 - mag;
      if (mag == 0) return 32'h0;
      p = 0;
      for (int i = 0; i < 33; i++) if (mag[i]) p = i;
      up = 1'b0;
      if (p <= 23) begin
         keep = mag << (23 - p);
      end else begin
         keep = mag >> (p - 23);
         rem  = mag - (keep << (p - 23));
         half = longint'(1) << (p - 24);
         case (rm)
            2'd0:    up = (rem > half) || (rem == half && keep[0]);
            2'd1:    up = 1'b0;
            2'd2:    up = !neg && rem != 0;
            default: up = neg && rem != 0;
         endcase
         if (up) keep++;
         if (keep == (longint'(1) << 24)) begin
            keep = keep >> 1;
            p++;
         end
      end
      return {neg, 8'(127 + p), keep[22:0]};
   endfunction

   function automatic logic [32:0] ref_ftoi(input logic [31:0] x, input logic [1:0] rm);
      int     e, ex, sh;
      longint m, ip, rem, half;
      bit     neg, gt, eq, nz, up, big;
      neg = x[31];
      e   = int'(x[30:23]);
      m   = longint'(x[22:0]);
      if (e == 255) return {1'b1, (x[22:0] != 0 || !neg) ? 32'h7FFFFFFF : 32'h80000000};
      if (e == 0) ex = -126;
      else begin
         ex = e - 127;
         m  = m + (longint'(1) << 23);
      end
      sh = 23 - ex;
      big = 0; gt = 0; eq = 0; nz = 0; ip = 0; up = 0;
      if (sh <= 0) begin
         if (-sh > 30) big = 1;
         else ip = m << (-sh);
      end else if (sh > 40) begin
         nz = (m != 0);
      end else begin
         ip   = m >> sh;
         rem  = m - (ip << sh);
         half = longint'(1) << (sh - 1);
         gt   = rem > half;
         eq   = rem == half;
         nz   = rem != 0;
      end
      case (rm)
         2'd0:    up = gt || (eq && ip[0]);
         2'd1:    up = 1'b0;
         2'd2:    up = !neg && nz;
         default: up = neg && nz;
      endcase
      if (up) ip++;
      if (big || (!neg && ip > 64'sd2147483647) || (neg && ip > 64'sd2147483648))
         return {1'b1, neg ? 32'h80000000 : 32'h7FFFFFFF};
      return {1'b0, neg ? 32'(-ip) : 32'(ip)};
   endfunction

   task automatic run_cvt(input logic [7:0] fn, input logic [31:0] op, input logic [1:0] rm,
                          input logic [32:0] exp, input string req);
      int lat;
      @(negedge clk);
      in_valid = 1'b1; in_func = fn; in_opnd = op; in_rmode = rm;
      @(negedge clk);
      in_valid = 1'b0;
      lat = 1;
      while (!out_done && lat < 12) begin
         @(negedge clk);
         lat++;
      end
      note({out_invalid, out_result} == exp, req, {out_invalid, out_result}, exp);
      note(lat == 3, "R7 latency", 33'(lat), 33'd3);
      @(negedge clk);
      note(!out_done, "R7 single-cycle done", {32'd0, out_done}, 33'd0);
   endtask

   initial begin
      logic [31:0] held;
      int          seen;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      note(out_done == 1'b0 && out_invalid == 1'b0 && out_result == 32'h0, "R10 reset state",
           {out_invalid, out_result}, 33'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 exact and special integer inputs
      run_cvt(FN_I2F, 32'h00000000, 2'd0, {1'b0, 32'h00000000}, "R2 zero");
      run_cvt(FN_I2F, 32'h80000000, 2'd0, {1'b0, 32'hCF000000}, "R2 most negative");
      run_cvt(FN_I2F, 32'hFFFFFFFF, 2'd0, {1'b0, 32'hBF800000}, "R2 minus one");
      run_cvt(FN_I2F, 32'h01000000, 2'd0, {1'b0, 32'h4B800000}, "R2 two to 24");
      // R1 rounding of wide integers
      run_cvt(FN_I2F, 32'h01000001, 2'd0, {1'b0, 32'h4B800000}, "R1 tie to even down");
      run_cvt(FN_I2F, 32'h01000003, 2'd0, {1'b0, 32'h4B800002}, "R1 tie to even up");
      run_cvt(FN_I2F, 32'h01000001, 2'd1, {1'b0, 32'h4B800000}, "R1 toward zero");
      run_cvt(FN_I2F, 32'h01000001, 2'd2, {1'b0, 32'h4B800001}, "R1 toward +inf");
      run_cvt(FN_I2F, 32'hFEFFFFFF, 2'd3, {1'b0, 32'hCB800001}, "R1 toward -inf negative");
      run_cvt(FN_I2F, 32'hFEFFFFFF, 2'd2, {1'b0, 32'hCB800000}, "R1 toward +inf negative");
      run_cvt(FN_I2F, 32'h7FFFFFFF, 2'd0, {1'b0, 32'h4F000000}, "R1 carry into exponent");
      run_cvt(FN_I2F, 32'h7FFFFFFF, 2'd1, {1'b0, 32'h4EFFFFFF}, "R1 truncated max");
      // R3 float-to-int rounding
      run_cvt(FN_F2I, 32'h3FC00000, 2'd0, {1'b0, 32'd2}, "R3 1.5 nearest");
      run_cvt(FN_F2I, 32'h3FC00000, 2'd1, {1'b0, 32'd1}, "R3 1.5 toward zero");
      run_cvt(FN_F2I, 32'h3FC00000, 2'd2, {1'b0, 32'd2}, "R3 1.5 toward +inf");
      run_cvt(FN_F2I, 32'h3FC00000, 2'd3, {1'b0, 32'd1}, "R3 1.5 toward -inf");
      run_cvt(FN_F2I, 32'h40200000, 2'd0, {1'b0, 32'd2}, "R3 2.5 tie to even");
      run_cvt(FN_F2I, 32'hC0200000, 2'd0, {1'b0, 32'hFFFFFFFE}, "R3 -2.5 nearest");
      run_cvt(FN_F2I, 32'hC0200000, 2'd3, {1'b0, 32'hFFFFFFFD}, "R3 -2.5 toward -inf");
      run_cvt(FN_F2I, 32'h4EFFFFFF, 2'd0, {1'b0, 32'h7FFFFF80}, "R3 largest in range");
      // R4 saturation and invalid
      run_cvt(FN_F2I, 32'h7FC00000, 2'd0, {1'b1, 32'h7FFFFFFF}, "R4 NaN");
      run_cvt(FN_F2I, 32'hFF800000, 2'd0, {1'b1, 32'h80000000}, "R4 -inf");
      run_cvt(FN_F2I, 32'h7F800000, 2'd0, {1'b1, 32'h7FFFFFFF}, "R4 +inf");
      run_cvt(FN_F2I, 32'h4F000000, 2'd0, {1'b1, 32'h7FFFFFFF}, "R4 two to 31");
      run_cvt(FN_F2I, 32'hCF000000, 2'd0, {1'b0, 32'h80000000}, "R4 exact minus two to 31");
      run_cvt(FN_F2I, 32'hCF000001, 2'd0, {1'b1, 32'h80000000}, "R4 below minus two to 31");
      // R5 small and denormal values
      run_cvt(FN_F2I, 32'h00000001, 2'd2, {1'b0, 32'd1}, "R5 denormal toward +inf");
      run_cvt(FN_F2I, 32'h00000001, 2'd3, {1'b0, 32'd0}, "R5 denormal toward -inf");
      run_cvt(FN_F2I, 32'h80000001, 2'd3, {1'b0, 32'hFFFFFFFF}, "R5 neg denormal toward -inf");
      run_cvt(FN_F2I, 32'h80000001, 2'd0, {1'b0, 32'd0}, "R5 neg denormal nearest");
      run_cvt(FN_F2I, 32'h80000000, 2'd2, {1'b0, 32'd0}, "R5 negative zero");
      run_cvt(FN_F2I, 32'h3F000000, 2'd0, {1'b0, 32'd0}, "R5 half to even");

      // R6 unknown function code ignored, R9 result held
      held = out_result;
      @(negedge clk);
      in_valid = 1'b1; in_func = 8'h06; in_opnd = 32'h3F800000; in_rmode = 2'd0;
      @(negedge clk);
      in_valid = 1'b0;
      seen = 0;
      for (int k = 0; k < 6; k++) begin
         if (out_done) seen++;
         @(negedge clk);
      end
      note(seen == 0, "R6 unknown code no done", 33'(seen), 33'd0);
      note(out_result == held, "R9 result held", {1'b0, out_result}, {1'b0, held});

      // R8 strobe held across the busy window
      @(negedge clk);
      in_valid = 1'b1; in_func = FN_I2F; in_opnd = 32'd5; in_rmode = 2'd0;
      @(negedge clk);
      in_func = FN_F2I; in_opnd = 32'h7FC00000;
      @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      note(out_done == 1'b1 && {out_invalid, out_result} == {1'b0, ref_itof(32'd5, 2'd0)},
           "R8 busy strobe ignored", {out_invalid, out_result}, {1'b0, ref_itof(32'd5, 2'd0)});
      seen = 0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (out_done) seen++;
      end
      note(seen == 0, "R8 no extra completion", 33'(seen), 33'd0);

      // random int-to-float (R1, R2)
      for (int k = 0; k < 1500; k++) begin
         logic [31:0] x;
         logic [1:0]  rm;
         x  = $urandom();
         if (k % 3 == 0) x = x >> ($urandom() % 32);
         rm = 2'($urandom() % 4);
         run_cvt(FN_I2F, x, rm, {1'b0, ref_itof(x, rm)}, "R1 random int-to-float");
      end

      // random float-to-int (R3, R4, R5)
      for (int k = 0; k < 1500; k++) begin
         logic [31:0] x;
         logic [1:0]  rm;
         logic [7:0]  ex;
         ex = (k % 4 == 0) ? 8'($urandom()) : 8'(100 + $urandom() % 70);
         x  = {1'($urandom()), ex, 23'($urandom())};
         rm = 2'($urandom() % 4);
         run_cvt(FN_F2I, x, rm, ref_ftoi(x, rm), "R3 random float-to-int");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule